// File: doc/BRIEF.md
# Pipelined Wide Multiply-Add Unit

This block multiplies two unsigned 64-bit operands into a full 128-bit product and can add an unsigned 64-bit term to it in the same operation. The result is a 128-bit value. One shared datapath serves both the high and the low half of that value. A single 64-bit result port carries the output, and each operation chooses which half goes out on it. A third choice sends both halves, one after the other, on two consecutive cycles.

The unit is fully pipelined. Every accepted operation passes through three register stages, whichever half it asks for. A new operation can be taken every cycle. The one exception is the single issue slot whose result would land on the port in the same cycle as the second half of a dual-half operation. The unit lowers `issue_ready` for that one slot.

When an operation asks for the add and the addend is all ones, a flag is raised in the cycle of issue. That case is the only one that can drive the high half to all ones.

Top module: `wide_muladd_unit`

## Requirements
- R1: With op code bits {dual,high,add} = 3'b000, an operation accepted at a clock edge gives the low 64 bits of a*b on `out_data`. It appears after the third edge, with `out_valid` high and `out_is_high` low.
- R2: With op bit 1 set (high half) and bit 2 clear, the result is bits 127:64 of the product, with the same three-edge latency.
- R3: With op bit 0 set (add), the 128-bit result is a*b+c. For a = b = c = 2^64-1 the high half is 2^64-1 and the low half is 0, with no lost carry.
- R4: With op bit 0 clear, the value on `in_c` has no effect on the result.
- R5: After a dual operation (op bit 2 set) is accepted, `issue_ready` is low for exactly the next cycle. An operation presented with `in_valid` in that cycle is dropped and produces no output.
- R6: A dual operation gives its low half, tagged low, three edges after issue. It gives its high half, tagged high, on the very next cycle. The value of op bit 1 does not matter for a dual operation.
- R7: Operations accepted on consecutive cycles come out on consecutive cycles, in order, one result per cycle.
- R8: `out_is_high` is 1 exactly when `out_data` carries bits 127:64, and `out_valid` is high only when `out_data` carries a result.
- R9: `addend_max` is high in a cycle exactly when an operation is accepted in that cycle with op bit 0 set and `in_c` equal to all ones.
- R10: A synchronous active-low reset drops every operation in flight, including a pending second half. After reset `out_valid` is low and `issue_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the issue bus |
| in_a | input | 64 | Multiplicand |
| in_b | input | 64 | Multiplier |
| in_c | input | 64 | Addend, used when op bit 0 is set |
| in_op | input | 3 | Bit 0 add, bit 1 high half, bit 2 both halves |
| issue_ready | output | 1 | Unit takes the presented operation this cycle |
| addend_max | output | 1 | Accepted add operation has an all-ones addend |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 64 | Selected 64-bit half of the result |
| out_is_high | output | 1 | `out_data` is the high half |

## Verification
The output port can be claimed by two things in the same cycle. One is the second half of a dual operation. The other is the fresh result of an operation issued one slot after it. The bench provokes this by issuing a dual operation and then, in the very next cycle, presenting another operation with distinct operands. It then issues again as soon as `issue_ready` returns. The outcome is judged at the port: the high half must appear tagged high in the cycle after the low half, the dropped operation must never appear, and the following operation must arrive one cycle later with its own value.

// File: rtl/wmad_pkg.sv
// Shared types for the wide multiply-add unit.
// Assumes: op code bit 0 = add, bit 1 = high half, bit 2 = both halves.
package wmad_pkg;

    localparam int OP_ADD  = 0;
    localparam int OP_HIGH = 1;
    localparam int OP_DUAL = 2;

    // Control that travels alongside the data through every stage.
    typedef struct packed {
        logic use_add;   // addend participates
        logic want_high; // single-half request: 1 = high
        logic dual;      // both halves, low then high
        logic cmax;      // addend was all ones at issue
    } wmad_ctl_t;

endpackage

// File: rtl/wmad_issue.sv
// Issue stage: takes an operation from the bus into stage 1.
// It forces the addend to zero for a plain multiply, raises the all-ones
// addend flag and blocks the single issue slot after a dual op.
// Assumes: the caller holds the op on the bus until issue_ready is seen.
module wmad_issue
    import wmad_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [DW-1:0] in_c,
    input  logic [2:0]    in_op,
    output logic          issue_ready,
    output logic          addend_max,
    output logic          s1_valid,
    output logic [DW-1:0] s1_a,
    output logic [DW-1:0] s1_b,
    output logic [DW-1:0] s1_c,
    output wmad_ctl_t     s1_ctl
);

    logic      accept;
    wmad_ctl_t nxt_ctl;

    // Ready unless stage 1 holds a dual op, whose second half owns the next port slot.
    always_comb begin
        issue_ready = !(s1_valid && s1_ctl.dual);
        accept      = in_valid && issue_ready;
    end

    // Decode the op code and detect the all-ones addend corner case.
    always_comb begin
        nxt_ctl.use_add   = in_op[OP_ADD];
        nxt_ctl.want_high = in_op[OP_HIGH];
        nxt_ctl.dual      = in_op[OP_DUAL];
        nxt_ctl.cmax      = in_op[OP_ADD] && (&in_c);
        addend_max        = accept && nxt_ctl.cmax;
    end

    // Stage 1 register: capture operands, zero the addend for a plain multiply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else begin
            s1_valid <= accept;
        end
        s1_a   <= in_a;
        s1_b   <= in_b;
        s1_c   <= in_op[OP_ADD] ? in_c : '0;
        s1_ctl <= nxt_ctl;
    end

    // R5: the cycle after a dual op is accepted, nothing may issue.
    p_bubble_after_dual_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && issue_ready && in_op[OP_DUAL]) |=> !issue_ready);

endmodule

// File: rtl/wmad_array.sv
// Multiply-add array, stages 2 and 3.
// Stage 2 registers SEG*SEG partial products of SW x SW bits each.
// Stage 3 shifts them into place, sums them with the addend and registers
// the 2*DW-bit result.
// Assumes: SEG divides DW; (2^DW-1)^2 + 2^DW-1 < 2^(2*DW), so no carry out.
module wmad_array
    import wmad_pkg::*;
#(
    parameter int DW  = 64,
    parameter int SEG = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s1_valid,
    input  logic [DW-1:0]   s1_a,
    input  logic [DW-1:0]   s1_b,
    input  logic [DW-1:0]   s1_c,
    input  wmad_ctl_t       s1_ctl,
    output logic            s3_valid,
    output logic [2*DW-1:0] s3_sum,
    output wmad_ctl_t       s3_ctl
);

    localparam int SW  = DW / SEG;
    localparam int NPP = SEG * SEG;
    localparam int RW  = 2 * DW;

    logic [2*SW-1:0] prod [NPP];
    logic [2*SW-1:0] pp   [NPP];
    logic            s2_valid;
    logic [DW-1:0]   s2_c;
    wmad_ctl_t       s2_ctl;
    logic [RW-1:0]   sum_c;

    // One partial product per pair of operand segments.
    for (genvar i = 0; i < SEG; i++) begin : g_row
        for (genvar j = 0; j < SEG; j++) begin : g_col
            assign prod[i*SEG+j] = s1_a[i*SW +: SW] * s1_b[j*SW +: SW];
        end
    end

    // Stage 2 register: partial products, addend and control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
        end else begin
            s2_valid <= s1_valid;
        end
        pp     <= prod;
        s2_c   <= s1_c;
        s2_ctl <= s1_ctl;
    end

    // Align every partial product by segment weight and accumulate with the addend.
    always_comb begin
        sum_c = {{DW{1'b0}}, s2_c};
        for (int i = 0; i < SEG; i++) begin
            for (int j = 0; j < SEG; j++) begin
                sum_c = sum_c + ({{(RW-2*SW){1'b0}}, pp[i*SEG+j]} << ((i + j) * SW));
            end
        end
    end

    // Stage 3 register: full-width result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_valid <= 1'b0;
        end else begin
            s3_valid <= s2_valid;
        end
        s3_sum <= sum_c;
        s3_ctl <= s2_ctl;
    end

    // R3: an all-ones high half only comes from an op flagged at issue.
    p_max_hi_flagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_valid && (&s3_sum[RW-1:DW])) |-> s3_ctl.cmax);

endmodule

// File: rtl/wmad_drain.sv
// Output sequencer: picks the half for the result port and, for a dual op,
// holds the high half and sends it in the following cycle.
// Assumes: issue logic guarantees no stage-3 result in a second-half cycle.
module wmad_drain
    import wmad_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            s3_valid,
    input  logic [2*DW-1:0] s3_sum,
    input  wmad_ctl_t       s3_ctl,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic            out_is_high
);

    logic          sec_pending;
    logic [DW-1:0] sec_data;

    // Hold the high half of a dual op for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_pending <= 1'b0;
        end else begin
            sec_pending <= s3_valid && s3_ctl.dual;
        end
        sec_data <= s3_sum[2*DW-1:DW];
    end

    // Port mux: a pending second half, else the stage-3 result's selected half.
    always_comb begin
        out_valid   = sec_pending || s3_valid;
        out_is_high = 1'b0;
        out_data    = s3_sum[DW-1:0];
        if (sec_pending) begin
            out_is_high = 1'b1;
            out_data    = sec_data;
        end else if (s3_valid && !s3_ctl.dual && s3_ctl.want_high) begin
            out_is_high = 1'b1;
            out_data    = s3_sum[2*DW-1:DW];
        end
    end

    // R6: a second half never shares the port with a fresh result.
    p_no_port_clash_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pending |-> !s3_valid);

    // R6: a dual result is followed at once by a high-tagged output.
    p_second_half_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s3_valid && s3_ctl.dual) |=> (out_valid && out_is_high));

    // R8: a low-tagged output never comes from the hold register.
    p_tag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_is_high) |-> !sec_pending);

endmodule

// File: rtl/wide_muladd_unit.sv
// Top of the pipelined unsigned DW x DW multiply-add unit.
// It joins the issue stage, the two-stage array and the output sequencer.
// Latency is three edges for every half. Throughput is one op per cycle,
// except for one blocked slot after each dual op.
// Assumes: synchronous active-low reset; DW is even.
module wide_muladd_unit
    import wmad_pkg::*;
#(
    parameter int DW  = 64,
    parameter int SEG = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    input  logic [DW-1:0] in_c,
    input  logic [2:0]    in_op,
    output logic          issue_ready,
    output logic          addend_max,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_is_high
);

    logic            s1_valid;
    logic [DW-1:0]   s1_a;
    logic [DW-1:0]   s1_b;
    logic [DW-1:0]   s1_c;
    wmad_ctl_t       s1_ctl;
    logic            s3_valid;
    logic [2*DW-1:0] s3_sum;
    wmad_ctl_t       s3_ctl;

    wmad_issue #(.DW(DW)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_a        (in_a),
        .in_b        (in_b),
        .in_c        (in_c),
        .in_op       (in_op),
        .issue_ready (issue_ready),
        .addend_max  (addend_max),
        .s1_valid    (s1_valid),
        .s1_a        (s1_a),
        .s1_b        (s1_b),
        .s1_c        (s1_c),
        .s1_ctl      (s1_ctl)
    );

    wmad_array #(.DW(DW), .SEG(SEG)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .s1_valid (s1_valid),
        .s1_a     (s1_a),
        .s1_b     (s1_b),
        .s1_c     (s1_c),
        .s1_ctl   (s1_ctl),
        .s3_valid (s3_valid),
        .s3_sum   (s3_sum),
        .s3_ctl   (s3_ctl)
    );

    wmad_drain #(.DW(DW)) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .s3_valid    (s3_valid),
        .s3_sum      (s3_sum),
        .s3_ctl      (s3_ctl),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_is_high (out_is_high)
    );

    // R10: the cycle after reset is applied, the port is idle and issue is open.
    p_reset_clears_r10: assert property (@(posedge clk)
        (!rst_n) |=> (!out_valid && issue_ready));

endmodule

// File: tb/test_wide_muladd_unit.sv
// Directed bench for wide_muladd_unit.
// A port monitor compares every output against a queue of expected halves.
// Each expected half carries the cycle it is due in.
module test_wide_muladd_unit;

    localparam logic [63:0] ONES = '1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic [63:0] in_c = '0;
    logic [2:0]  in_op = '0;
    logic        issue_ready;
    logic        addend_max;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_is_high;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    typedef struct {
        int          due;
        logic [63:0] data;
        logic        hi;
        string       req;
    } exp_t;

    exp_t expq[$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wide_muladd_unit i_wide_muladd_unit (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_a        (in_a),
        .in_b        (in_b),
        .in_c        (in_c),
        .in_op       (in_op),
        .issue_ready (issue_ready),
        .addend_max  (addend_max),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_is_high (out_is_high)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Port monitor: every output must match the head of the expected queue (R1, R7, R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (expq.size() == 0 || expq[0].due != cyc) begin
                    check(1'b0, "R7 unexpected output", {63'd0, out_is_high, out_data}, '0);
                end else begin
                    check(out_data == expq[0].data && out_is_high == expq[0].hi,
                          expq[0].req, {63'd0, out_is_high, out_data},
                          {63'd0, expq[0].hi, expq[0].data});
                    void'(expq.pop_front());
                end
            end else if (expq.size() != 0 && expq[0].due <= cyc) begin
                check(1'b0, {expq[0].req, " missing output"}, '0, {63'd0, expq[0].hi, expq[0].data});
                void'(expq.pop_front());
            end
        end
    end

    // Present one op for one cycle; record the expected halves when it is taken (R9).
    task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [63:0] c,
                        input logic [2:0] op, input string req);
        logic [127:0] r;
        bit           taken;
        in_valid = 1'b1;
        in_a = a;
        in_b = b;
        in_c = c;
        in_op = op;
        #1;
        taken = issue_ready;
        check(addend_max == (taken && op[0] && c == ONES), "R9 addend_max flag",
              {127'd0, addend_max}, {127'd0, taken && op[0] && c == ONES});
        r = ({64'd0, a} * {64'd0, b}) + (op[0] ? {64'd0, c} : 128'd0);
        if (taken) begin
            if (op[2]) begin
                expq.push_back('{cyc + 3, r[63:0], 1'b0, {req, " dual low"}});
                expq.push_back('{cyc + 4, r[127:64], 1'b1, {req, " dual high"}});
            end else if (op[1]) begin
                expq.push_back('{cyc + 3, r[127:64], 1'b1, req});
            end else begin
                expq.push_back('{cyc + 3, r[63:0], 1'b0, req});
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Wait until every expected result has been seen.
    task automatic drain(input string req);
        for (int i = 0; i < 20 && expq.size() != 0; i++) @(negedge clk);
        check(expq.size() == 0, {req, " queue drained"}, 128'(expq.size()), '0);
        expq.delete();
    endtask

    task automatic t_reset_state;
        check(!out_valid, "R10 reset out_valid", {127'd0, out_valid}, '0);
        check(issue_ready, "R10 reset issue_ready", {127'd0, issue_ready}, 128'd1);
    endtask

    task automatic t_single_halves;
        send(64'd7, 64'd9, 64'd0, 3'b000, "R1 low 7*9");
        send(ONES, 64'd3, 64'd0, 3'b010, "R2 high max*3");
        send(64'h1234_5678_9abc_def0, 64'hfedc_ba98_7654_3210, 64'd0, 3'b000, "R8 low tag");
        send(64'h1234_5678_9abc_def0, 64'hfedc_ba98_7654_3210, 64'd0, 3'b010, "R8 high tag");
        drain("R1");
    endtask

    task automatic t_fused;
        send(ONES, ONES, ONES, 3'b011, "R3 max high");
        send(ONES, ONES, ONES, 3'b001, "R3 max low");
        send(64'd5, 64'd6, 64'd100, 3'b001, "R3 5*6+100");
        send(64'd5, 64'd6, ONES, 3'b000, "R4 addend ignored");
        send(ONES, ONES, 64'hdead_beef, 3'b010, "R4 high addend ignored");
        drain("R3");
    endtask

    task automatic t_dual;
        send(64'hffff_0000_ffff_0000, 64'h0001_0002_0003_0004, 64'd11, 3'b111, "R6 dual add");
        check(!issue_ready, "R5 ready low after dual", {127'd0, issue_ready}, '0);
        send(64'd1, 64'd1, 64'd0, 3'b000, "R5 dropped op");
        check(issue_ready, "R5 ready back", {127'd0, issue_ready}, 128'd1);
        send(64'd3, 64'd4, 64'd0, 3'b000, "R5 op after bubble");
        send(ONES, ONES, 64'd0, 3'b100, "R6 dual plain");
        send(64'd2, 64'd2, 64'd0, 3'b010, "R5 dropped op 2");
        drain("R6");
    endtask

    task automatic t_stream;
        for (int i = 1; i <= 8; i++) begin
            send(64'(i) * 64'h0f0f_0f0f_0f0f_0f0f, 64'(i * 977), 64'(i),
                 3'(i % 4), "R7 stream");
        end
        drain("R7");
    endtask

    task automatic t_reset_mid;
        send(ONES, 64'd5, 64'd0, 3'b100, "R10 flushed dual");
        send(64'd9, 64'd9, 64'd0, 3'b000, "R10 flushed");
        @(negedge clk);
        rst_n = 1'b0;
        expq.delete();
        @(negedge clk);
        check(!out_valid, "R10 mid reset out_valid", {127'd0, out_valid}, '0);
        check(issue_ready, "R10 mid reset issue_ready", {127'd0, issue_ready}, 128'd1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) @(negedge clk);
        send(64'd6, 64'd7, 64'd0, 3'b000, "R10 after reset");
        drain("R10");
    endtask

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_single_halves();
        t_fused();
        t_dual();
        t_stream();
        t_reset_mid();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule